// File: doc/BRIEF.md
# Monitor Slot Byte Transmitter

This block sends a message, one byte at a time, through a monitor slot that comes round once per frame on a shared open-drain line. Each slot holds `DATA_W` data bit times followed by one handshake bit time. That last bit carries this end's transmit-valid flag, MX, which is active low. In the same bit time the far end's receive-acknowledge flag, MR, also active low, is presented on `mrIn`. A `1` on `txBit` means the line is released, and `lineBit` returns the wired-AND value of the line.

The message arrives on a byte stream with valid/ready and a last-byte flag. A message may start only after the channel has been seen quiet for two frames in a row. The current byte, together with an active MX, is repeated every frame until the far end acknowledges it. The next byte then takes its place in the very next frame. After the last byte is acknowledged, the block releases the line.

While it drives, the block reads back every `1` it puts on the line. If the line reads `0` instead, another device is talking. The block then reports a collision, stops driving, throws away the rest of the message and goes back to waiting for a quiet channel.

Top module: `mon_tx`

## Requirements
- R1: While reset is active and directly after it, `txBit` is 1 (released), `inReady` is 0 and `collErr` is 0.
- R2: A slot has `DATA_W` data positions followed by one handshake position. Position 0 is the bit time on which `frameStart` and `bitStb` are both high. Data goes out most significant bit first at positions 0 to `DATA_W-1`, and MX goes out at position `DATA_W`. The position advances only on `bitStb`, and `txBit` changes only on a `bitStb` cycle or a `frameStart` cycle.
- R3: A message starts only after two consecutive handshake positions on which both `lineBit` and `mrIn` read 1. The first byte is accepted on the second of these handshake positions and is sent in the next frame with MX = 0. A handshake position on which another device holds MX low, or `mrIn` is 0, restarts the count.
- R4: A byte being sent is driven, with MX = 0, in every frame until it is acknowledged.
- R5: `mrIn` = 0 at the handshake position acknowledges the byte only if that byte was already sent in an earlier frame. `mrIn` = 0 in the byte's first frame is ignored and the byte is sent again.
- R6: When a byte that is not the last one is acknowledged, the next byte is accepted on that same handshake position and is sent in the immediately following frame.
- R7: After the last byte is acknowledged, MX and the data positions are released. A following message still has to satisfy R3, so the line stays released for at least two frames.
- R8: If no byte is offered when an acknowledge arrives, the line is released. A byte is accepted only at a later handshake position and is sent in the frame after that.
- R9: If the block drives a 1 and reads back 0 while sending, `collErr` pulses high for exactly one cycle in the next cycle, and `txBit` stays released from then on.
- R10: After a collision, `inReady` stays 1 until a byte with `inLast` set has been taken. None of the taken bytes is ever sent. A new message then waits for R3 again, counted from the frame after the collision.
- R11: A 0 read back where the block drove 0, or while it is not sending, never raises `collErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bitStb | input | 1 | One cycle per bit time of the slot |
| frameStart | input | 1 | Marks position 0 of the slot, together with `bitStb` |
| lineBit | input | 1 | Wired-AND value read back from the line |
| mrIn | input | 1 | Far end's MR flag, sampled at the handshake position, active low |
| inValid | input | 1 | Stream byte valid |
| inData | input | DATA_W | Stream byte |
| inLast | input | 1 | Byte is the last byte of the message |
| inReady | output | 1 | Stream byte is taken when this and `inValid` are both high |
| txBit | output | 1 | Value driven on the line for the current position, 1 = released |
| collErr | output | 1 | One-cycle pulse reporting a collision and abort |

## Verification
The bench acts as the far end. It goes after the off-by-one frame counts:
- A block that starts after one quiet frame shows MX low one frame early.
- A block that honours an MR present in a byte's first frame skips the repeat.
- A block that waits a frame after an acknowledge leaves a released frame between bytes.

In the collision cases, a wrong block would either keep driving after the mismatch or send bytes that should have been flushed; the bench catches both in the frames that follow. It also pulls low bits that the block drives low, and pulls the line while the block is idle, so that a collision check which ignores the transmitted value gives a false error. A stall case covers a late source, where a block that is wrong keeps MX active over a byte it does not hold.

// File: rtl/mon_tx_pkg.sv
`timescale 1ns/1ps
package mon_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_STALL,
    ST_FLUSH
  } txState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sending;
  } dpCtrl_t;

  // per-bit observations from datapath to control
  typedef struct packed {
    logic slotEnd;
    logic collide;
    logic slotIdle;
    logic mrActive;
  } dpStat_t;

endpackage

// File: rtl/mon_tx_dp.sv
`timescale 1ns/1ps
module mon_tx_dp
  import mon_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStb,
  input  logic              frameStart,
  input  logic              lineBit,
  input  logic              mrIn,
  input  logic [DATA_W-1:0] inData,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  output logic              txBit
);
  localparam int SLOT_BITS = DATA_W + 1;
  localparam int POS_W = $clog2(SLOT_BITS);
  localparam logic [POS_W-1:0] MX_POS = POS_W'(DATA_W);

  logic [POS_W-1:0]     pos;
  logic [POS_W-1:0]     curPos;
  logic [DATA_W-1:0]    curByte;
  logic [SLOT_BITS-1:0] slotWord;

  // frameStart realigns the bit counter to position 0
  assign curPos = frameStart ? '0 : pos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (bitStb) begin
      pos <= (curPos == MX_POS) ? '0 : curPos + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curByte <= '0;
    end else if (ctrl.load) begin
      curByte <= inData;
    end
  end

  // slot image: MSB first, active-low MX in the last position
  generate
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_order
      assign slotWord[gi] = curByte[DATA_W-1-gi];
    end
  endgenerate
  assign slotWord[DATA_W] = 1'b0;

  assign txBit = ctrl.sending ? slotWord[curPos] : 1'b1;

  always_comb begin
    stat.slotEnd  = bitStb && (curPos == MX_POS);
    stat.collide  = bitStb && ctrl.sending && txBit && !lineBit;
    stat.slotIdle = lineBit && mrIn;
    stat.mrActive = !mrIn;
  end

endmodule

// File: rtl/mon_tx_ctrl.sv
`timescale 1ns/1ps
module mon_tx_ctrl
  import mon_tx_pkg::*;
#(
  parameter int IDLE_FRAMES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  dpStat_t stat,
  input  logic    inValid,
  input  logic    inLast,
  output logic    inReady,
  output dpCtrl_t ctrl,
  output logic    collErr
);
  localparam int CNT_W = $clog2(IDLE_FRAMES + 1);
  localparam logic [CNT_W-1:0] IDLE_NEED = CNT_W'(IDLE_FRAMES - 1);

  txState_e       state;
  txState_e       stateNext;
  logic [CNT_W-1:0] idleCnt;
  logic           sentOnce;
  logic           curLast;
  logic           errQ;
  logic           idleOk;
  logic           ackNow;
  logic           take;

  always_comb begin
    idleOk = stat.slotEnd && stat.slotIdle && (idleCnt >= IDLE_NEED);
    ackNow = (state == ST_SEND) && stat.slotEnd && sentOnce && stat.mrActive;
    unique case (state)
      ST_IDLE:  inReady = idleOk;
      ST_SEND:  inReady = ackNow && !curLast;
      ST_STALL: inReady = stat.slotEnd;
      default:  inReady = !curLast;
    endcase
    take         = inReady && inValid;
    ctrl.load    = take && (state != ST_FLUSH);
    ctrl.sending = (state == ST_SEND);

    stateNext = state;
    unique case (state)
      ST_IDLE: if (take) stateNext = ST_SEND;
      ST_SEND: begin
        if (stat.collide) begin
          stateNext = ST_FLUSH;
        end else if (ackNow) begin
          if (curLast)   stateNext = ST_IDLE;
          else if (take) stateNext = ST_SEND;
          else           stateNext = ST_STALL;
        end
      end
      ST_STALL: if (take) stateNext = ST_SEND;
      default:  if (stat.slotEnd && curLast) stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      idleCnt  <= '0;
      sentOnce <= 1'b0;
      curLast  <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= stat.collide;

      if (state != ST_IDLE) begin
        idleCnt <= '0;
      end else if (stat.slotEnd) begin
        if (!stat.slotIdle)          idleCnt <= '0;
        else if (idleCnt < IDLE_NEED) idleCnt <= idleCnt + 1'b1;
      end

      if (ctrl.load) begin
        sentOnce <= 1'b0;
      end else if ((state == ST_SEND) && stat.slotEnd) begin
        sentOnce <= 1'b1;
      end

      // also marks "drained" while flushing
      if (take) curLast <= inLast;
    end
  end

  assign collErr = errQ;

endmodule

// File: rtl/mon_tx.sv
`timescale 1ns/1ps
module mon_tx
  import mon_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDLE_FRAMES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitStb,
  input  logic              frameStart,
  input  logic              lineBit,
  input  logic              mrIn,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              inReady,
  output logic              txBit,
  output logic              collErr
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  mon_tx_dp #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bitStb     (bitStb),
    .frameStart (frameStart),
    .lineBit    (lineBit),
    .mrIn       (mrIn),
    .inData     (inData),
    .ctrl       (ctrl),
    .stat       (stat),
    .txBit      (txBit)
  );

  mon_tx_ctrl #(.IDLE_FRAMES(IDLE_FRAMES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .inValid (inValid),
    .inLast  (inLast),
    .inReady (inReady),
    .ctrl    (ctrl),
    .collErr (collErr)
  );

endmodule

// File: rtl/mon_tx_chk.sv
`timescale 1ns/1ps
module mon_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitStb,
  input logic frameStart,
  input logic lineBit,
  input logic txBit,
  input logic collErr
);

  // R9
  err_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    collErr |=> !collErr);

  // R9
  err_releases_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    collErr |-> txBit);

  // R11
  err_needs_low_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    collErr |-> $past(bitStb && !lineBit));

  // R2
  drive_holds_between_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!frameStart && $past(!bitStb && !frameStart)) |-> $stable(txBit));

endmodule

bind mon_tx mon_tx_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .bitStb     (bitStb),
  .frameStart (frameStart),
  .lineBit    (lineBit),
  .txBit      (txBit),
  .collErr    (collErr)
);

// File: tb/mon_tx_bench.sv
`timescale 1ns/1ps
module mon_tx_bench;
  localparam int W = 8;
  localparam int S = W + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitStb = 1'b0;
  logic frameStart = 1'b0;
  logic mrIn = 1'b1;
  logic pull = 1'b0;
  logic lineBit, inValid, inLast, inReady, txBit, collErr;
  logic [W-1:0] inData;

  logic [W-1:0] msgBuf [16];
  int msgLen = 0;
  int avail = 0;
  int srcIdx = 0;
  int total = 0;
  int bad = 0;
  int errCnt = 0;
  bit done = 1'b0;
  logic [S-1:0] frBits;

  assign lineBit = txBit & ~pull;
  assign inValid = (srcIdx < msgLen) && (srcIdx < avail);
  assign inData  = msgBuf[srcIdx % 16];
  assign inLast  = (srcIdx == msgLen - 1);

  always #2.5 clk = ~clk;

  mon_tx #(.DATA_W(W), .IDLE_FRAMES(2)) u_mon_tx (
    .clk(clk), .rstN(rstN), .bitStb(bitStb), .frameStart(frameStart),
    .lineBit(lineBit), .mrIn(mrIn), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inReady(inReady), .txBit(txBit), .collErr(collErr)
  );

  function automatic logic [S-1:0] slotOf(logic [W-1:0] b);
    logic [S-1:0] s;
    for (int p = 0; p < W; p++) s[p] = b[W-1-p];
    s[W] = 1'b0;
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic stb, input logic fs, input logic pl, input logic mr, input int p);
    bit hs;
    @(negedge clk);
    bitStb = stb; frameStart = fs; pull = pl; mrIn = mr;
    #1;
    if (stb) frBits[p] = txBit;
    if (collErr) errCnt++;
    hs = inValid && inReady;
    @(posedge clk);
    #1;
    if (hs) srcIdx++;
  endtask

  task automatic runFrame(input logic mr, input int pullPos);
    errCnt = 0;
    for (int p = 0; p < S; p++) begin
      cyc(1'b1, p == 0, p == pullPos, mr, p);
      cyc(1'b0, 1'b0, 1'b0, mr, p);
    end
  endtask

  task automatic newMsg(input int len);
    for (int k = 0; k < 16; k++) msgBuf[k] = W'($urandom);
    srcIdx = 0; msgLen = len; avail = len;
  endtask

  task automatic idleFrames(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      runFrame(1'b1, int'($urandom_range(0, W - 1)));
      chk(frBits == '1, req, 32'(frBits), 32'h1ff);
      chk(errCnt == 0, "R11 idle pull", errCnt, 0);
    end
  endtask

  task automatic sendByte(input int i, input int d, input logic firstMr, input bit pullMx);
    for (int f = 0; f <= d; f++) begin
      runFrame((f == 0) ? firstMr : ((f == d) ? 1'b0 : 1'b1), pullMx ? W : -1);
      if (f == 0 && i > 0)
        chk(frBits == slotOf(msgBuf[i]), "R6 next byte", 32'(frBits), 32'(slotOf(msgBuf[i])));
      else if (f == 1 && firstMr == 1'b0)
        chk(frBits == slotOf(msgBuf[i]), "R5 early MR ignored", 32'(frBits), 32'(slotOf(msgBuf[i])));
      else
        chk(frBits == slotOf(msgBuf[i]), "R4 repeat", 32'(frBits), 32'(slotOf(msgBuf[i])));
      chk(errCnt == 0, "R11 low bit pulled", errCnt, 0);
    end
  endtask

  task automatic runMessage(input int len);
    newMsg(len);
    idleFrames(2, "R7 gap before start");
    chk(srcIdx == 1, "R3 first byte taken", srcIdx, 1);
    for (int i = 0; i < len; i++)
      sendByte(i, 1 + int'($urandom % 3), logic'($urandom % 2), bit'($urandom % 2));
    chk(srcIdx == len, "R6 all bytes taken", srcIdx, len);
  endtask

  initial begin
    void'($urandom(32'd2741));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(txBit == 1'b1, "R1 txBit", txBit, 1);
    chk(inReady == 1'b0, "R1 inReady", inReady, 0);
    chk(collErr == 1'b0, "R1 collErr", collErr, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(txBit == 1'b1 && collErr == 1'b0, "R1 after release", {txBit, collErr}, 2'b10);

    // R3: busy line and active MR hold off the start
    newMsg(3);
    runFrame(1'b1, W);
    chk(frBits == '1, "R3 other MX low", 32'(frBits), 32'h1ff);
    runFrame(1'b1, W);
    chk(frBits == '1, "R3 other MX low", 32'(frBits), 32'h1ff);
    runFrame(1'b0, -1);
    chk(frBits == '1, "R3 MR active", 32'(frBits), 32'h1ff);
    idleFrames(1, "R3 one quiet frame");
    chk(srcIdx == 0, "R3 not started after one", srcIdx, 0);
    idleFrames(1, "R3 second quiet frame");
    chk(srcIdx == 1, "R3 start on second", srcIdx, 1);
    for (int i = 0; i < 3; i++) sendByte(i, 1 + (i % 2), logic'(i == 1), 1'b0);

    // random messages
    for (int m = 0; m < 10; m++) runMessage(1 + int'($urandom % 5));

    // R8 stall
    newMsg(3);
    avail = 1;
    idleFrames(2, "R3 before stall");
    sendByte(0, 1, 1'b1, 1'b0);
    idleFrames(2, "R8 released in stall");
    avail = 3;
    idleFrames(1, "R8 accept frame released");
    chk(srcIdx == 2, "R8 accepted at slot end", srcIdx, 2);
    sendByte(1, 2, 1'b0, 1'b0);
    sendByte(2, 1, 1'b1, 1'b1);

    // R9 R10 collision on first send, rest flushed
    newMsg(4);
    msgBuf[0] = 8'hA5;
    idleFrames(2, "R3 before collision");
    runFrame(1'b1, 0);
    chk(errCnt == 1, "R9 one pulse", errCnt, 1);
    chk(frBits == '1, "R9 released after", 32'(frBits), 32'h1ff);
    chk(srcIdx == 4, "R10 flushed", srcIdx, 4);
    runMessage(2);

    // R11 pulled zero bit, then R9 collision on repeat of a single-byte message
    newMsg(1);
    msgBuf[0] = 8'h01;
    idleFrames(2, "R3 before second collision");
    runFrame(1'b1, 0);
    chk(frBits == slotOf(8'h01), "R11 zero bit pulled", 32'(frBits), 32'(slotOf(8'h01)));
    chk(errCnt == 0, "R11 no error", errCnt, 0);
    runFrame(1'b1, W - 1);
    chk(errCnt == 1, "R9 pulse on repeat", errCnt, 1);
    chk(frBits == {1'b1, slotOf(8'h01)[W-1:0]}, "R9 MX released",
        32'(frBits), 32'({1'b1, slotOf(8'h01)[W-1:0]}));
    chk(srcIdx == 1, "R10 last already taken", srcIdx, 1);
    runMessage(3);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule